// File: doc/BRIEF.md
# Inter-Stage Delay Ring

This block carries per-cycle records from one pipeline stage to another with a fixed latency. It holds a ring of slots. Each slot stores a count of valid entries and up to `MAX_RECS` fixed-width records. Every port names a slot by a signed offset from a rotating base pointer, never by a physical position. The producer writes at offset zero or at a small positive offset. The consumer reads at offset `-D` and so sees what was written `D` cycles earlier.

The producer stores a whole slot in one cycle: the count and all record lanes together. At the end of a pipeline cycle the owner pulses `adv_i` once. That pulse rotates the base by one slot and empties the slot that wraps round to become the furthest-future one. If a write and an advance come in the same cycle, the write goes into the slot selected before the rotation. The read port is combinational from the slot storage. An offset outside the legal window raises an error flag. An out-of-range write changes nothing, and an out-of-range read returns zeros.

Top module: `stage_delay_ring`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, every legal read offset returns count 0 and all-zero records.
- R2: A write with `wr_en_i` high and a legal offset `k` (0..FUTURE_DEPTH), and no advance, stores `wr_cnt_i` and `wr_recs_i` into that slot. From the next cycle onward they are read back at offset `k`.
- R3: Each `adv_i` pulse moves every stored slot down by one offset: what was readable at offset `r` becomes readable at `r-1`.
- R4: Data written at offset 0 is read at offset `-D` after exactly `D` advances, for every `D` in 0..PAST_DEPTH.
- R5: An advance empties the slot that becomes offset FUTURE_DEPTH, giving count 0 and zero records. That slot reads as zero once it has moved into the read window, unless it is written again.
- R6: When a legal write and an advance fall in the same cycle, the write lands at offset `k` of the old base and is read at `k-1` afterwards.
- R7: `wr_off_err_o` is high exactly when `wr_off_i` lies outside 0..FUTURE_DEPTH. Such a write changes no slot.
- R8: `rd_off_err_o` is high exactly when `rd_off_i` lies outside -PAST_DEPTH..0. In that case `rd_cnt_o` and `rd_recs_o` are zero.
- R9: In a cycle with neither an advance nor a legal write, no slot changes.
- R10: Behaviour stays correct across any number of rotations, with the base wrapping from `SIZE-1` back to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adv_i | input | 1 | End-of-cycle rotate pulse |
| wr_en_i | input | 1 | Write strobe |
| wr_off_i | input | OFF_W (signed) | Write offset, legal range 0..FUTURE_DEPTH |
| wr_cnt_i | input | CNT_W | Valid-entry count to store |
| wr_recs_i | input | MAX_RECS*REC_W | Record lanes to store, lane 0 in the low bits |
| rd_off_i | input | OFF_W (signed) | Read offset, legal range -PAST_DEPTH..0 |
| rd_cnt_o | output | CNT_W | Count of the addressed slot |
| rd_recs_o | output | MAX_RECS*REC_W | Records of the addressed slot |
| wr_off_err_o | output | 1 | Write offset out of range |
| rd_off_err_o | output | 1 | Read offset out of range |

## Verification
A wrong base pointer or a wrong wrap shows at once. In the cycle after the fault, a sweep over every read offset finds data at an offset one step away from where it should be. A slot that is not emptied on rotation stays hidden for a short while. It appears as stale non-zero data once it reaches offset 0, which takes at most FUTURE_DEPTH advances. The bench therefore runs every read offset, legal or not, in every cycle against a shifting reference model. That catches both kinds of fault within a few cycles.

// File: rtl/ring_pkg.sv
package ring_pkg;

  // Bring a base-plus-offset sum back into 0..size-1 (one fold at most).
  function automatic int wrap_index(input int raw, input int size);
    if (raw >= size) return raw - size;
    else if (raw < 0) return raw + size;
    return raw;
  endfunction

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Signed width large enough for -past..future plus one illegal step each way.
  function automatic int off_width(input int past, input int future);
    int m;
    m = (past > future) ? past : future;
    return $clog2(m + 2) + 1;
  endfunction

endpackage

// File: rtl/ring_index_map.sv
module ring_index_map #(
  parameter int SIZE  = 4,
  parameter int LO    = -2,
  parameter int HI    = 0,
  parameter int OFF_W = 3,
  parameter int IDX_W = 2
) (
  input  logic [IDX_W-1:0]        base_i,
  input  logic signed [OFF_W-1:0] off_i,
  output logic [IDX_W-1:0]        idx_o,
  output logic                    err_o
);

  int off_val;
  int raw_sum;
  int folded;

  always_comb begin
    off_val = int'(off_i);
    raw_sum = int'(base_i) + off_val;
    err_o   = (off_val < LO) || (off_val > HI);
    folded  = ring_pkg::wrap_index(raw_sum, SIZE);
    idx_o   = err_o ? '0 : IDX_W'(folded);
  end

endmodule

// File: rtl/ring_base_ctr.sv
module ring_base_ctr #(
  parameter int SIZE  = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_i,
  output logic [IDX_W-1:0] base_o
);

  logic [IDX_W-1:0] base_q;
  logic [IDX_W-1:0] base_d;

  always_comb begin
    if (base_q == IDX_W'(SIZE - 1)) base_d = '0;
    else                            base_d = base_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     base_q <= '0;
    else if (adv_i) base_q <= base_d;
  end

  assign base_o = base_q;

endmodule

// File: rtl/ring_slot.sv
module ring_slot #(
  parameter int REC_W    = 8,
  parameter int MAX_RECS = 2,
  parameter int CNT_W    = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_i,
  input  logic                      clr_i,
  input  logic [CNT_W-1:0]          cnt_i,
  input  logic [MAX_RECS*REC_W-1:0] recs_i,
  output logic [CNT_W-1:0]          cnt_o,
  output logic [MAX_RECS*REC_W-1:0] recs_o
);

  logic [CNT_W-1:0]          cnt_q, cnt_d;
  logic [MAX_RECS*REC_W-1:0] recs_q, recs_d;
  logic                      en;

  assign en = wr_i | clr_i;

  always_comb begin
    if (wr_i) begin
      cnt_d  = cnt_i;
      recs_d = recs_i;
    end else begin
      cnt_d  = '0;
      recs_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      recs_q <= '0;
    end else if (en) begin
      cnt_q  <= cnt_d;
      recs_q <= recs_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign recs_o = recs_q;

endmodule

// File: rtl/stage_delay_ring.sv
module stage_delay_ring #(
  parameter int PAST_DEPTH   = 2,
  parameter int FUTURE_DEPTH = 1,
  parameter int REC_W        = 8,
  parameter int MAX_RECS     = 2,
  localparam int SIZE  = PAST_DEPTH + FUTURE_DEPTH + 1,
  localparam int IDX_W = ring_pkg::idx_width(SIZE),
  localparam int OFF_W = ring_pkg::off_width(PAST_DEPTH, FUTURE_DEPTH),
  localparam int CNT_W = $clog2(MAX_RECS + 1),
  localparam int DAT_W = MAX_RECS * REC_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    adv_i,
  input  logic                    wr_en_i,
  input  logic signed [OFF_W-1:0] wr_off_i,
  input  logic [CNT_W-1:0]        wr_cnt_i,
  input  logic [DAT_W-1:0]        wr_recs_i,
  input  logic signed [OFF_W-1:0] rd_off_i,
  output logic [CNT_W-1:0]        rd_cnt_o,
  output logic [DAT_W-1:0]        rd_recs_o,
  output logic                    wr_off_err_o,
  output logic                    rd_off_err_o
);

  logic [IDX_W-1:0] base;
  logic [IDX_W-1:0] wr_idx;
  logic [IDX_W-1:0] rd_idx;
  logic [IDX_W-1:0] clr_idx;
  logic             wr_err;
  logic             rd_err;
  int               clr_raw;

  logic [CNT_W-1:0] slot_cnt  [SIZE];
  logic [DAT_W-1:0] slot_recs [SIZE];
  logic [SIZE-1:0]  slot_wr;
  logic [SIZE-1:0]  slot_clr;

  ring_base_ctr #(.SIZE(SIZE), .IDX_W(IDX_W)) u_base (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv_i  (adv_i),
    .base_o (base)
  );

  ring_index_map #(
    .SIZE(SIZE), .LO(0), .HI(FUTURE_DEPTH), .OFF_W(OFF_W), .IDX_W(IDX_W)
  ) u_wr_map (
    .base_i (base),
    .off_i  (wr_off_i),
    .idx_o  (wr_idx),
    .err_o  (wr_err)
  );

  ring_index_map #(
    .SIZE(SIZE), .LO(-PAST_DEPTH), .HI(0), .OFF_W(OFF_W), .IDX_W(IDX_W)
  ) u_rd_map (
    .base_i (base),
    .off_i  (rd_off_i),
    .idx_o  (rd_idx),
    .err_o  (rd_err)
  );

  // The slot recycled by a rotation sits one beyond the newest future slot.
  always_comb begin
    clr_raw = int'(base) + FUTURE_DEPTH + 1;
    clr_idx = IDX_W'(ring_pkg::wrap_index(clr_raw, SIZE));
  end

  for (genvar s = 0; s < SIZE; s++) begin : g_slot
    assign slot_wr[s]  = wr_en_i && !wr_err && (wr_idx == IDX_W'(s));
    assign slot_clr[s] = adv_i && (clr_idx == IDX_W'(s));

    ring_slot #(.REC_W(REC_W), .MAX_RECS(MAX_RECS), .CNT_W(CNT_W)) u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_i   (slot_wr[s]),
      .clr_i  (slot_clr[s]),
      .cnt_i  (wr_cnt_i),
      .recs_i (wr_recs_i),
      .cnt_o  (slot_cnt[s]),
      .recs_o (slot_recs[s])
    );
  end

  always_comb begin
    rd_cnt_o  = '0;
    rd_recs_o = '0;
    for (int s = 0; s < SIZE; s++) begin
      if (!rd_err && rd_idx == IDX_W'(s)) begin
        rd_cnt_o  = slot_cnt[s];
        rd_recs_o = slot_recs[s];
      end
    end
  end

  assign wr_off_err_o = wr_err;
  assign rd_off_err_o = rd_err;

endmodule

// File: rtl/stage_delay_ring_checker.sv
module stage_delay_ring_checker #(
  parameter int PAST_DEPTH = 2,
  parameter int OFF_W      = 3,
  parameter int CNT_W      = 2,
  parameter int DAT_W      = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    adv_i,
  input logic                    wr_en_i,
  input logic signed [OFF_W-1:0] wr_off_i,
  input logic [CNT_W-1:0]        wr_cnt_i,
  input logic signed [OFF_W-1:0] rd_off_i,
  input logic [CNT_W-1:0]        rd_cnt_o,
  input logic [DAT_W-1:0]        rd_recs_o,
  input logic                    wr_off_err_o,
  input logic                    rd_off_err_o
);

  assert_rd_err_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_off_err_o |-> (rd_cnt_o == '0 && rd_recs_o == '0));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_i && !wr_en_i) |=> ($past(rd_off_i) != rd_off_i || $stable(rd_cnt_o)));

  assert_bad_wr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_i && wr_en_i && wr_off_err_o) |=> ($past(rd_off_i) != rd_off_i || $stable(rd_recs_o)));

  assert_wr_visible_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !wr_off_err_o && wr_off_i == '0 && !adv_i)
      |=> (rd_off_i != '0 || rd_cnt_o == $past(wr_cnt_i)));

  assert_shift_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !wr_en_i && rd_off_i == '0)
      |=> (PAST_DEPTH < 1 || rd_off_i != -1 || rd_cnt_o == $past(rd_cnt_o)));

endmodule

bind stage_delay_ring stage_delay_ring_checker #(
  .PAST_DEPTH (PAST_DEPTH),
  .OFF_W      (OFF_W),
  .CNT_W      (CNT_W),
  .DAT_W      (DAT_W)
) u_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .adv_i        (adv_i),
  .wr_en_i      (wr_en_i),
  .wr_off_i     (wr_off_i),
  .wr_cnt_i     (wr_cnt_i),
  .rd_off_i     (rd_off_i),
  .rd_cnt_o     (rd_cnt_o),
  .rd_recs_o    (rd_recs_o),
  .wr_off_err_o (wr_off_err_o),
  .rd_off_err_o (rd_off_err_o)
);

// File: tb/tb_stage_delay_ring.sv
module tb_stage_delay_ring;

  localparam int CLK_PERIOD = 20;
  localparam int PAST  = 2;
  localparam int FUT   = 1;
  localparam int RW    = 8;
  localparam int NR    = 2;
  localparam int SZ    = PAST + FUT + 1;
  localparam int OW    = ring_pkg::off_width(PAST, FUT);
  localparam int CW    = $clog2(NR + 1);
  localparam int DW    = NR * RW;
  localparam int OMIN  = -(1 << (OW - 1));
  localparam int OMAX  = (1 << (OW - 1)) - 1;

  logic clk;
  logic rst_n;
  logic adv;
  logic wen;
  logic signed [OW-1:0] woff;
  logic [CW-1:0] wcnt;
  logic [DW-1:0] wrecs;
  logic signed [OW-1:0] roff;
  logic [CW-1:0] rcnt;
  logic [DW-1:0] rrecs;
  logic werr;
  logic rerr;

  int n_cmp;
  int n_bad;
  bit done;

  // reference slots indexed by offset + PAST
  int unsigned   m_cnt [SZ];
  logic [DW-1:0] m_rec [SZ];

  stage_delay_ring #(
    .PAST_DEPTH(PAST), .FUTURE_DEPTH(FUT), .REC_W(RW), .MAX_RECS(NR)
  ) dut (
    .clk(clk), .rst_n(rst_n), .adv_i(adv), .wr_en_i(wen), .wr_off_i(woff),
    .wr_cnt_i(wcnt), .wr_recs_i(wrecs), .rd_off_i(roff), .rd_cnt_o(rcnt),
    .rd_recs_o(rrecs), .wr_off_err_o(werr), .rd_off_err_o(rerr)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic cmp(input string tag, input int off, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s off=%0d actual=%0h expected=%0h", tag, off, act, exp);
    end
  endtask

  task automatic sweep_reads(input string tag);
    for (int ro = OMIN; ro <= OMAX; ro++) begin
      bit bad;
      roff = OW'(ro);
      #1;
      bad = (ro < -PAST) || (ro > 0);
      cmp("R8", ro, longint'(rerr), longint'(bad));
      if (bad) begin
        cmp("R8", ro, longint'(rcnt), 0);
        cmp("R8", ro, longint'(rrecs), 0);
      end else begin
        cmp(tag, ro, longint'(rcnt), longint'(m_cnt[ro + PAST]));
        cmp(tag, ro, longint'(rrecs), longint'(m_rec[ro + PAST]));
      end
    end
  endtask

  // Called just after a falling edge; returns just after the next falling edge.
  task automatic step(input string tag, input bit a, input bit w, input int wo,
                      input int c, input logic [DW-1:0] d);
    bit wbad;
    adv = a; wen = w; woff = OW'(wo); wcnt = CW'(c); wrecs = d;
    #1;
    wbad = (wo < 0) || (wo > FUT);
    cmp("R7", wo, longint'(werr), longint'(wbad));
    sweep_reads(tag);
    @(posedge clk);
    if (w && !wbad) begin
      m_cnt[wo + PAST] = c;
      m_rec[wo + PAST] = d;
    end
    if (a) begin
      for (int r = 0; r < SZ - 1; r++) begin
        m_cnt[r] = m_cnt[r + 1];
        m_rec[r] = m_rec[r + 1];
      end
      m_cnt[SZ - 1] = 0;
      m_rec[SZ - 1] = '0;
    end
    @(negedge clk);
    adv = 1'b0; wen = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    n_cmp = 0; n_bad = 0; done = 1'b0;
    for (int r = 0; r < SZ; r++) begin
      m_cnt[r] = 0;
      m_rec[r] = '0;
    end
    rst_n = 1'b0; adv = 1'b0; wen = 1'b0; woff = '0; wcnt = '0; wrecs = '0; roff = '0;
    repeat (3) @(negedge clk);
    sweep_reads("R1");
    rst_n = 1'b1;
    @(negedge clk);

    // R1: state just after reset
    step("R1", 1'b0, 1'b0, 0, 0, '0);
    // R2: writes at each legal offset, no rotation
    step("R2", 1'b0, 1'b1, 0, 2, 16'hA1B2);
    step("R2", 1'b0, 1'b1, 1, 1, 16'h0C3D);
    step("R2", 1'b0, 1'b0, 0, 0, '0);
    // R9: idle cycles hold everything
    repeat (3) step("R9", 1'b0, 1'b0, 0, 0, '0);
    // R3 / R4: rotations move data downward through every read offset
    step("R3", 1'b1, 1'b0, 0, 0, '0);
    step("R4", 1'b1, 1'b0, 0, 0, '0);
    step("R4", 1'b1, 1'b0, 0, 0, '0);
    // R5: fill all future slots then rotate to expose the recycled slots
    step("R5", 1'b0, 1'b1, 0, 2, 16'hFFFF);
    step("R5", 1'b0, 1'b1, 1, 2, 16'hEEEE);
    repeat (SZ + 1) step("R5", 1'b1, 1'b0, 0, 0, '0);
    // R6: write plus rotation in the same cycle
    step("R6", 1'b1, 1'b1, 0, 1, 16'h1234);
    step("R6", 1'b1, 1'b1, 1, 2, 16'h5678);
    step("R6", 1'b0, 1'b0, 0, 0, '0);
    // R7: illegal write offsets leave all slots untouched
    for (int wo = OMIN; wo <= OMAX; wo++) begin
      if (wo < 0 || wo > FUT) step("R7", 1'b0, 1'b1, wo, 1, 16'hDEAD);
    end
    step("R7", 1'b0, 1'b0, 0, 0, '0);
    // R10: long mixed run across many base wraps
    for (int i = 0; i < 1500; i++) begin
      int wo;
      wo = int'($urandom_range(OMAX - OMIN)) + OMIN;
      step("R10", 1'($urandom_range(1)), 1'($urandom_range(1)), wo,
           int'($urandom_range(NR)), DW'($urandom));
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule